// File: doc/BRIEF.md
# Watermark-Gated Interrupt Controller

This block holds the interrupt cause status and the cause mask of a network device and drives one interrupt request line towards the host processor. Event sources inside the device raise cause bits with single-cycle pulses. A small register write port lets software clear status bits (write-one-to-clear), replace the mask, set the global interrupt enable, inject a software cause and program a posting delay.

Two watermark causes are filtered by hysteresis. The receive-high cause reaches the line only if the receive FIFO has reported empty since that cause last got through. The transmit-low cause reaches the line only if the transmit FIFO has reported full since it last got through. Causes outside a configurable no-delay set are held back by a programmable number of cycles. A request never pushes an already scheduled, earlier assertion later. Once the line is up, further requests add nothing until the line is withdrawn.

Write selector codes on `wr_sel_i`: 0 status clear, 1 mask, 2 configuration (bit 0 = interrupt enable), 3 command (bit 0 = inject software cause), 4 delay.

Cause bit positions: 0 software, 1 receive-high, 2 receive-packet, 3 transmit-low, 4 transmit-packet, 5 receive-DMA, 6 transmit-DMA, 7 receive-empty, 8 transmit-full. Bits 15..9 are reserved. The default no-delay set is bits 0 and 8.

Top module: `irqc_ctrl`

## Requirements
- R1: Two clock edges after reset release, the block is in its reset state: status is 0x0000, mask is 0x000F (software, receive-high, receive-packet and transmit-low), the line is low, the enable is off and the delay is 0.
- R2: An event pulse ORs its bits into status. A pulse that has any reserved bit (15..9) set changes nothing.
- R3: A write with selector 0 clears exactly the status bits set in the written value. A clear value with any reserved bit set changes nothing.
- R4: While the enable (configuration bit 0) is off, posts update status but the line stays low.
- R5: A post whose masked, gated set holds a no-delay cause (bit 0 or 8) raises the line one edge after the edge that captures the post. Otherwise the line rises D+1 edges after it, where D is the delay register.
- R6: A new request replaces the pending schedule only if it is due earlier. An earlier pending schedule is kept and fires at its own time.
- R7: Receive-high (bit 1) is dropped from a post unless `rx_empty_i` was seen high at an earlier edge since the cause last got through. Getting through consumes that permission.
- R8: Transmit-low (bit 3) is dropped from a post unless `tx_full_i` was seen high at an earlier edge since the cause last got through. Getting through consumes that permission.
- R9: A clear that leaves status AND mask at zero lowers the line at that same edge. A clear that leaves some masked cause set keeps the line high, and further posts never re-raise it.
- R10: A mask write that changes the mask while the enable is on and status AND new mask is nonzero raises the line one edge later, whatever the delay.
- R11: Setting the enable while status AND mask is nonzero raises the line one edge later. Clearing the enable lowers the line at that edge.
- R12: A command write with bit 0 set posts the software cause (status bit 0).
- R13: With the delay register at 0, every cause is posted as fast as a no-delay cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 16 | Cause pulse bits from device event sources |
| rx_empty_i | input | 1 | Receive FIFO empty flag, arms receive-high |
| tx_full_i | input | 1 | Transmit FIFO full flag, arms transmit-low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register selector (0 status, 1 mask, 2 config, 3 command, 4 delay) |
| wr_data_i | input | 16 | Register write value |
| irq_o | output | 1 | Interrupt request line to the host |
| status_o | output | 16 | Current cause status |
| mask_o | output | 16 | Current cause mask |

## Verification
If the hysteresis permission is wrongly held or lost, the line either rises on a watermark cause that should be dropped, or stays low when it should rise. Either shows one edge after a zero-delay post. A corrupted countdown moves the rising edge of `irq_o` away from the D+1 edge the bench expects, so replace-versus-keep faults show as a line that rises a few cycles early or late. Status and mask faults appear on `status_o` and `mask_o` right after the edge that applies the write or event.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // cause bit positions
  localparam int CAUSE_SOFT     = 0;
  localparam int CAUSE_RX_HIGH  = 1;
  localparam int CAUSE_RX_PKT   = 2;
  localparam int CAUSE_TX_LOW   = 3;
  localparam int CAUSE_TX_PKT   = 4;
  localparam int CAUSE_RX_DMA   = 5;
  localparam int CAUSE_TX_DMA   = 6;
  localparam int CAUSE_RX_EMPTY = 7;
  localparam int CAUSE_TX_FULL  = 8;

  // control bit positions
  localparam int CFG_EN_BIT   = 0;
  localparam int CMD_SOFT_BIT = 0;

  typedef enum logic [2:0] {
    SEL_STATUS  = 3'd0,
    SEL_MASK    = 3'd1,
    SEL_CONFIG  = 3'd2,
    SEL_COMMAND = 3'd3,
    SEL_DELAY   = 3'd4
  } wr_sel_e;
endpackage

// File: rtl/irqc_hyst.sv
// Hysteresis gate for one watermark cause: passes the cause once per arming.
module irqc_hyst (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic cand_i,
  output logic pass_o
);
  logic armed_q;
  logic armed_d;

  assign pass_o = cand_i & armed_q;

  always_comb begin
    armed_d = arm_i | (armed_q & ~cand_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  // R7 / R8: a cause that got through consumes the permission
  assert_consume_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_o && !arm_i) |=> !armed_q);
endmodule

// File: rtl/irqc_sched.sv
// Single-slot deferred assertion scheduler: earliest request wins.
module irqc_sched #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [DLY_W-1:0] req_delay_i,
  input  logic             cancel_i,
  output logic             fire_o
);
  logic             valid_q, valid_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             keep;

  assign fire_o = valid_q && (cnt_q == '0);
  assign keep   = valid_q && (cnt_q <= req_delay_i);

  always_comb begin
    valid_d = valid_q;
    cnt_d   = cnt_q;
    if (cancel_i) begin
      valid_d = 1'b0;
    end else if (req_i && !keep) begin
      valid_d = 1'b1;
      cnt_d   = req_delay_i;
    end else if (valid_q) begin
      if (cnt_q == '0) valid_d = 1'b0;
      else             cnt_d   = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      valid_q <= valid_d;
      cnt_q   <= cnt_d;
    end
  end

  // R6: a later request never disturbs a running countdown
  assert_count_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && cnt_q != '0 && !cancel_i && !(req_i && req_delay_i < cnt_q))
    |=> (valid_q && cnt_q == $past(cnt_q) - 1'b1));

  // R9: a schedule fires exactly once
  assert_single_fire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl import irqc_pkg::*; #(
  parameter int                  CAUSE_W      = 16,
  parameter int                  NUM_CAUSES   = 9,
  parameter int                  DLY_W        = 16,
  parameter logic [CAUSE_W-1:0]  NODELAY_MASK = 16'h0101
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_W-1:0] evt_i,
  input  logic               rx_empty_i,
  input  logic               tx_full_i,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_sel_i,
  input  logic [CAUSE_W-1:0] wr_data_i,
  output logic               irq_o,
  output logic [CAUSE_W-1:0] status_o,
  output logic [CAUSE_W-1:0] mask_o
);
  localparam logic [CAUSE_W-1:0] USED_MASK  = (CAUSE_W'(1) << NUM_CAUSES) - CAUSE_W'(1);
  localparam logic [CAUSE_W-1:0] RES_MASK   = ~USED_MASK;
  localparam logic [CAUSE_W-1:0] RESET_MASK =
    (CAUSE_W'(1) << CAUSE_SOFT)   | (CAUSE_W'(1) << CAUSE_RX_HIGH) |
    (CAUSE_W'(1) << CAUSE_RX_PKT) | (CAUSE_W'(1) << CAUSE_TX_LOW);
  localparam int NUM_HYST = 2;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // architectural state
  logic [CAUSE_W-1:0] status_q, status_d;
  logic [CAUSE_W-1:0] mask_q,   mask_d;
  logic               en_q,     en_d;
  logic [DLY_W-1:0]   delay_q,  delay_d;
  logic               pend_q,   pend_d;

  // decode
  logic wr_status, wr_mask, wr_cfg, wr_cmd, wr_dly;
  assign wr_status = wr_en_i && (wr_sel_i == SEL_STATUS);
  assign wr_mask   = wr_en_i && (wr_sel_i == SEL_MASK);
  assign wr_cfg    = wr_en_i && (wr_sel_i == SEL_CONFIG);
  assign wr_cmd    = wr_en_i && (wr_sel_i == SEL_COMMAND);
  assign wr_dly    = wr_en_i && (wr_sel_i == SEL_DELAY);

  logic               clr_ok;
  logic [CAUSE_W-1:0] clr_bits, post_bits, live, active_raw, active;
  logic               post_eval;
  logic [NUM_HYST-1:0] hy_arm, hy_cand, hy_pass;

  always_comb begin
    clr_ok    = wr_status && ((wr_data_i & RES_MASK) == '0);
    clr_bits  = clr_ok ? wr_data_i : '0;
    post_bits = ((evt_i & RES_MASK) == '0) ? evt_i : '0;
    if (wr_cmd && wr_data_i[CMD_SOFT_BIT])
      post_bits[CAUSE_SOFT] = 1'b1;
    status_d  = (status_q & ~clr_bits) | post_bits;
    mask_d    = wr_mask ? (wr_data_i & USED_MASK) : mask_q;
    en_d      = wr_cfg ? wr_data_i[CFG_EN_BIT] : en_q;
    delay_d   = wr_dly ? DLY_W'(wr_data_i) : delay_q;
    live      = status_d & mask_d;
    post_eval = |post_bits;
  end

  assign active_raw = post_eval ? live : '0;

  // watermark hysteresis, one gate per watermark cause
  assign hy_arm = {tx_full_i, rx_empty_i};
  generate
    for (genvar g = 0; g < NUM_HYST; g++) begin : g_hyst
      localparam int BIT = (g == 0) ? CAUSE_RX_HIGH : CAUSE_TX_LOW;
      assign hy_cand[g] = active_raw[BIT];
      irqc_hyst u_hyst (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .arm_i  (hy_arm[g]),
        .cand_i (hy_cand[g]),
        .pass_o (hy_pass[g])
      );
    end
  endgenerate

  always_comb begin
    active                = active_raw;
    active[CAUSE_RX_HIGH] = hy_pass[0];
    active[CAUSE_TX_LOW]  = hy_pass[1];
  end

  // request / withdraw generation
  logic             post_req, mask_req, en_req, en_fall, withdraw, req, fire;
  logic [DLY_W-1:0] req_delay;

  always_comb begin
    post_req  = post_eval && (|active) && en_q && en_d;
    mask_req  = wr_mask && (mask_d != mask_q) && (|live) && en_q;
    en_req    = wr_cfg && wr_data_i[CFG_EN_BIT] && !en_q && (|live);
    en_fall   = wr_cfg && !wr_data_i[CFG_EN_BIT] && en_q;
    withdraw  = (clr_ok && (live == '0)) || en_fall;
    req       = post_req || mask_req || en_req;
    if (mask_req || en_req || ((active & NODELAY_MASK) != '0))
      req_delay = '0;
    else
      req_delay = delay_q;
  end

  irqc_sched #(.DLY_W(DLY_W)) u_sched (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req_i       (req),
    .req_delay_i (req_delay),
    .cancel_i    (withdraw),
    .fire_o      (fire)
  );

  always_comb begin
    pend_d = pend_q;
    if (withdraw)  pend_d = 1'b0;
    else if (fire) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      status_q <= '0;
      mask_q   <= RESET_MASK;
      en_q     <= 1'b0;
      delay_q  <= '0;
      pend_q   <= 1'b0;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
      en_q     <= en_d;
      delay_q  <= delay_d;
      pend_q   <= pend_d;
    end
  end

  assign irq_o    = pend_q;
  assign status_o = status_q;
  assign mask_o   = mask_q;

  // R4: the line is only up while enabled
  assert_irq_enabled_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o |-> en_q);

  // R2: reserved cause bits never reach status
  assert_reserved_clear_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (status_q & RES_MASK) == '0);

  // R3: write-one-to-clear on a quiet cycle
  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en_i && wr_sel_i == SEL_STATUS && (wr_data_i & RES_MASK) == '0 && evt_i == '0)
    |=> status_q == ($past(status_q) & ~$past(wr_data_i)));

  // R9: a clear leaving nothing masked withdraws the line
  assert_withdraw_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en_i && wr_sel_i == SEL_STATUS && (wr_data_i & RES_MASK) == '0 && evt_i == '0
     && (status_q & ~wr_data_i & mask_q) == '0) |=> !irq_o);

  // R5: the line only rises from a scheduler firing
  assert_irq_rise_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq_o) |-> $past(fire));
endmodule

// File: tb/sim_irqc_ctrl.sv
`timescale 1ns/1ps
module sim_irqc_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] evt;
  logic        rx_empty, tx_full;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [15:0] wr_data;
  logic        irq;
  logic [15:0] status, mask;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  irqc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .rx_empty_i(rx_empty),
    .tx_full_i(tx_full), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .irq_o(irq), .status_o(status), .mask_o(mask)
  );

  // {op, data, exp_status, exp_mask}; op 7 = event pulse, else write selector
  localparam int NV = 9;
  localparam logic [50:0] VEC [NV] = '{
    {3'd7, 16'h0004, 16'h0004, 16'h000F},  // R2 post
    {3'd7, 16'h0010, 16'h0014, 16'h000F},  // R2 OR in
    {3'd7, 16'h0200, 16'h0014, 16'h000F},  // R2 reserved rejected
    {3'd0, 16'h0004, 16'h0010, 16'h000F},  // R3 clear
    {3'd0, 16'h8010, 16'h0010, 16'h000F},  // R3 reserved clear rejected
    {3'd1, 16'h00F0, 16'h0010, 16'h00F0},  // R4 mask overlap while disabled
    {3'd3, 16'h0001, 16'h0011, 16'h00F0},  // R12 soft inject
    {3'd0, 16'h0011, 16'h0000, 16'h00F0},  // R3 clear all
    {3'd1, 16'h000F, 16'h0000, 16'h000F}   // restore mask
  };

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic post(input logic [15:0] bits);
    evt = bits;
    tick();
    evt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evt = '0; rx_empty = 1'b0; tx_full = 1'b0;
    wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    tick(4);
    @(negedge clk) rst_n = 1'b1;
    tick(3);

    // R1 reset state
    check("R1", "status", status, 16'h0000);
    check("R1", "mask", mask, 16'h000F);
    check("R1", "irq", {15'd0, irq}, 16'h0000);

    // vector table, interrupts disabled throughout (R4)
    for (int i = 0; i < NV; i++) begin
      logic [2:0]  op;
      logic [15:0] d, es, em;
      {op, d, es, em} = VEC[i];
      if (op == 3'd7) post(d);
      else            wr(op, d);
      check("R2/R3/R12", "table status", status, es);
      check("R2/R3/R12", "table mask", mask, em);
      check("R4", "table irq", {15'd0, irq}, 16'h0000);
    end

    // R5 delayed cause
    wr(3'd2, 16'h0001);
    wr(3'd4, 16'd5);
    post(16'h0004);
    tick(5);
    check("R5", "irq before delay", {15'd0, irq}, 16'h0000);
    tick();
    check("R5", "irq after delay", {15'd0, irq}, 16'h0001);
    wr(3'd0, 16'h0004);
    check("R9", "irq withdrawn", {15'd0, irq}, 16'h0000);

    // R5 no-delay cause
    post(16'h0001);
    check("R5", "nodelay irq at capture", {15'd0, irq}, 16'h0000);
    tick();
    check("R5", "nodelay irq", {15'd0, irq}, 16'h0001);
    wr(3'd0, 16'h0001);

    // R9 partial clear keeps line, extra posts add nothing
    post(16'h0005);
    tick();
    check("R9", "irq up", {15'd0, irq}, 16'h0001);
    post(16'h0001);
    tick(2);
    check("R9", "irq stays", {15'd0, irq}, 16'h0001);
    wr(3'd0, 16'h0001);
    check("R9", "partial clear keeps irq", {15'd0, irq}, 16'h0001);
    wr(3'd0, 16'h0004);
    check("R9", "full clear drops irq", {15'd0, irq}, 16'h0000);

    // R6 earlier request replaces a later schedule
    wr(3'd4, 16'd10);
    post(16'h0004);
    tick(3);
    wr(3'd4, 16'd2);
    post(16'h0004);
    tick(2);
    check("R6", "replaced not yet", {15'd0, irq}, 16'h0000);
    tick();
    check("R6", "replaced fires early", {15'd0, irq}, 16'h0001);
    wr(3'd0, 16'h0004);

    // R6 earlier schedule kept
    wr(3'd4, 16'd3);
    post(16'h0004);
    wr(3'd4, 16'd20);
    post(16'h0004);
    tick();
    check("R6", "kept not yet", {15'd0, irq}, 16'h0000);
    tick();
    check("R6", "kept fires on time", {15'd0, irq}, 16'h0001);
    wr(3'd0, 16'h0004);

    // R13 zero delay
    wr(3'd4, 16'd0);
    post(16'h0004);
    check("R13", "irq at capture", {15'd0, irq}, 16'h0000);
    tick();
    check("R13", "irq immediate", {15'd0, irq}, 16'h0001);
    wr(3'd0, 16'h0004);

    // R7 receive-high hysteresis
    post(16'h0002);
    tick(3);
    check("R7", "unarmed status", status, 16'h0002);
    check("R7", "unarmed irq", {15'd0, irq}, 16'h0000);
    wr(3'd0, 16'h0002);
    rx_empty = 1'b1; tick(); rx_empty = 1'b0;
    post(16'h0002);
    tick();
    check("R7", "armed irq", {15'd0, irq}, 16'h0001);
    wr(3'd0, 16'h0002);
    post(16'h0002);
    tick(3);
    check("R7", "consumed irq", {15'd0, irq}, 16'h0000);
    wr(3'd0, 16'h0002);

    // R8 transmit-low hysteresis
    post(16'h0008);
    tick(3);
    check("R8", "unarmed irq", {15'd0, irq}, 16'h0000);
    wr(3'd0, 16'h0008);
    tx_full = 1'b1; tick(); tx_full = 1'b0;
    post(16'h0008);
    tick();
    check("R8", "armed irq", {15'd0, irq}, 16'h0001);
    wr(3'd0, 16'h0008);
    post(16'h0008);
    tick(3);
    check("R8", "consumed irq", {15'd0, irq}, 16'h0000);
    wr(3'd0, 16'h0008);

    // R10 mask change posts immediately
    wr(3'd1, 16'h0000);
    post(16'h0010);
    tick(2);
    check("R10", "masked irq", {15'd0, irq}, 16'h0000);
    wr(3'd4, 16'd8);
    wr(3'd1, 16'h0010);
    check("R10", "irq at mask edge", {15'd0, irq}, 16'h0000);
    tick();
    check("R10", "irq after mask", {15'd0, irq}, 16'h0001);
    wr(3'd0, 16'h0010);
    wr(3'd1, 16'h000F);

    // R11 enable edge behaviour
    wr(3'd2, 16'h0000);
    post(16'h0004);
    tick(10);
    check("R11", "disabled irq", {15'd0, irq}, 16'h0000);
    wr(3'd2, 16'h0001);
    tick();
    check("R11", "enable posts", {15'd0, irq}, 16'h0001);
    wr(3'd2, 16'h0000);
    check("R11", "disable drops", {15'd0, irq}, 16'h0000);
    wr(3'd0, 16'h0004);
    check("R3", "final status", status, 16'h0000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule